// File: doc/BRIEF.md
# Mixed-Length Instruction Aligner and Add Decoder

This block sits after instruction fetch. Each cycle it may accept an eight-byte window of program memory, taken little-endian at the current program counter, so bit 0 of the instruction is bit 0 of the first byte. The low four bits of the window alone decide how long the next instruction is: two bytes for the narrow form, eight bytes for a wide bundle, three bytes for everything else. Narrow, base and wide instructions can follow one another in any order, and nothing has to switch the decoder between them.

Narrow and base instructions carry three 4-bit register fields. A destination field `d` sits at bits 15:12, a first source `a` at bits 11:8 and a second source `b` at bits 7:4. The add in either length writes the sum of the two source registers into the destination, in a file of sixteen 32-bit registers. A base word with any other opcode raises a one-cycle illegal flag and leaves the file untouched. A wide bundle is not decoded here: its raw 64-bit word is presented on an output for one cycle. The program counter steps by the detected length on every accepted window. A seed write port and a read port give access to the register file so that its contents can be observed.

Top module: `mixlen_decode_core`

## Requirements
- R1: While `rst_n` is low and after reset, `pc` equals the parameter `RESET_PC` (default 0), all sixteen registers read 0, and `illegal` and `wide_valid` are 0.
- R2: The instruction length comes from window bits 3:0. The value 4'b1010 gives 2 bytes, 4'b1110 gives 8 bytes and any other value gives 3 bytes. On each clock edge with `win_valid` high, `pc` grows by that length, modulo 2^PC_W.
- R3: `win_ready` is always 1. On an edge with `win_valid` low, `pc`, the register file, `illegal` and `wide_valid` are unaffected, apart from the pulse flags returning to 0.
- R4: A 3-byte window with bits 23:16 = 8'h80 and bits 3:0 = 4'h0 is the base add. At the accepting edge, register `d` (bits 15:12) takes register `a` (bits 11:8) + register `b` (bits 7:4), modulo 2^32.
- R5: A 2-byte window (bits 3:0 = 4'hA) is the narrow add, with `d`, `a` and `b` in the same bit positions. It writes the same sum at the accepting edge.
- R6: The add reads its sources before the write lands. This holds when `d` equals a source, and back-to-back adds see the previous result.
- R7: A 3-byte window that is not the base add sets `illegal` to 1 for the one cycle after the accepting edge. The register file is not written.
- R8: A wide window (bits 3:0 = 4'hE) sets `wide_valid` to 1 for the one cycle after the accepting edge. During that cycle `wide_word` holds the whole 64-bit window, and the register file is not written.
- R9: On an edge where `seed_we` is high, register `seed_addr` takes `seed_data`. If an add writes the same register at that edge, the add wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Byte window is valid |
| win_bytes | input | 64 | Eight bytes at pc, first byte in bits 7:0 |
| win_ready | output | 1 | Window accepted (always 1) |
| pc | output | 32 | Program counter |
| illegal | output | 1 | One-cycle pulse after a non-add 3-byte window |
| wide_valid | output | 1 | One-cycle pulse after a wide bundle |
| wide_word | output | 64 | Raw wide bundle, valid with wide_valid |
| seed_we | input | 1 | Register seed write enable |
| seed_addr | input | 4 | Register seed address |
| seed_data | input | 32 | Register seed data |
| rd_addr | input | 4 | Observation read address |
| rd_data | output | 32 | Register contents at rd_addr (combinational) |

## Verification
On every cycle, the assertions check a few properties. The program counter either holds or steps by 2, 3 or 8. An idle edge leaves it alone. The illegal and wide pulses never come together, and each pulse follows an accepted window of the matching kind. A register write only ever follows an accepted add or a seed. Only the bench's scenarios can show the arithmetic: that the correct destination gets the correct sum, that an overlapping destination and source read the old value, and that illegal and wide windows leave all sixteen registers intact. The bench's reference model compares the program counter and both pulses against its own prediction on every clock, and sweeps the file through the read port after each scenario.

// File: rtl/mixlen_pkg.sv
package mixlen_pkg;
  typedef enum logic [1:0] {
    FMT_NARROW = 2'd0,
    FMT_BASE   = 2'd1,
    FMT_WIDE   = 2'd2
  } fmt_e;

  localparam logic [3:0] NIB_NARROW = 4'b1010;
  localparam logic [3:0] NIB_WIDE   = 4'b1110;
  localparam logic [7:0] BASE_ADD_HI = 8'h80;

  function automatic fmt_e fmt_of(input logic [3:0] nib);
    if (nib == NIB_NARROW) return FMT_NARROW;
    if (nib == NIB_WIDE)   return FMT_WIDE;
    return FMT_BASE;
  endfunction

  function automatic logic [3:0] bytes_of(input fmt_e f);
    case (f)
      FMT_NARROW: return 4'd2;
      FMT_WIDE:   return 4'd8;
      default:    return 4'd3;
    endcase
  endfunction

  function automatic logic [31:0] add_wrap(input logic [31:0] x, input logic [31:0] y);
    return x + y;
  endfunction
endpackage

// File: rtl/mixlen_len_detect.sv
module mixlen_len_detect
  import mixlen_pkg::*;
(
  input  logic [3:0] low_nib,
  output fmt_e       fmt,
  output logic [3:0] len_bytes
);
  always_comb begin
    fmt       = fmt_of(low_nib);
    len_bytes = bytes_of(fmt);
  end
endmodule

// File: rtl/mixlen_field_decode.sv
module mixlen_field_decode
  import mixlen_pkg::*;
(
  input  logic [23:0] word,
  input  fmt_e        fmt,
  output logic [3:0]  dst,
  output logic [3:0]  src_a,
  output logic [3:0]  src_b,
  output logic        is_add,
  output logic        is_bad
);
  logic base_add;
  always_comb begin
    dst      = word[15:12];
    src_a    = word[11:8];
    src_b    = word[7:4];
    base_add = (word[23:16] == BASE_ADD_HI) && (word[3:0] == 4'h0);
    is_add   = (fmt == FMT_NARROW) || ((fmt == FMT_BASE) && base_add);
    is_bad   = (fmt == FMT_BASE) && !base_add;
  end
endmodule

// File: rtl/mixlen_regfile.sv
module mixlen_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_obs,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  output logic [DW-1:0] rd_obs,
  input  logic          we_op,
  input  logic [AW-1:0] wa_op,
  input  logic [DW-1:0] wd_op,
  input  logic          we_seed,
  input  logic [AW-1:0] wa_seed,
  input  logic [DW-1:0] wd_seed,
  output logic          any_write
);
  logic [DW-1:0] regs [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic hit_op, hit_seed;
    assign hit_op   = we_op   && (wa_op   == AW'(gi));
    assign hit_seed = we_seed && (wa_seed == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        regs[gi] <= '0;
      else if (hit_op)   regs[gi] <= wd_op;
      else if (hit_seed) regs[gi] <= wd_seed;
    end
  end

  assign rd_a      = regs[ra_a];
  assign rd_b      = regs[ra_b];
  assign rd_obs    = regs[ra_obs];
  assign any_write = we_op || we_seed;
endmodule

// File: rtl/mixlen_decode_core.sv
module mixlen_decode_core
  import mixlen_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          NREG     = 16,
  parameter int          DW       = 32,
  parameter int          WIN_B    = 8,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         AW       = $clog2(NREG),
  localparam int         WIN_W    = WIN_B * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [WIN_W-1:0] win_bytes,
  output logic             win_ready,
  output logic [PC_W-1:0]  pc,
  output logic             illegal,
  output logic             wide_valid,
  output logic [WIN_W-1:0] wide_word,
  input  logic             seed_we,
  input  logic [AW-1:0]    seed_addr,
  input  logic [DW-1:0]    seed_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);
  fmt_e          fmt;
  logic [3:0]    len_bytes;
  logic [3:0]    f_dst, f_a, f_b;
  logic          dec_add, dec_bad;
  logic [DW-1:0] opa, opb;
  logic          accept, do_add, rf_wrote;

  assign win_ready = 1'b1;
  assign accept    = win_valid && win_ready;
  assign do_add    = accept && dec_add;

  mixlen_len_detect u_len (
    .low_nib  (win_bytes[3:0]),
    .fmt      (fmt),
    .len_bytes(len_bytes)
  );

  mixlen_field_decode u_dec (
    .word  (win_bytes[23:0]),
    .fmt   (fmt),
    .dst   (f_dst),
    .src_a (f_a),
    .src_b (f_b),
    .is_add(dec_add),
    .is_bad(dec_bad)
  );

  mixlen_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_a     (f_a[AW-1:0]),
    .ra_b     (f_b[AW-1:0]),
    .ra_obs   (rd_addr),
    .rd_a     (opa),
    .rd_b     (opb),
    .rd_obs   (rd_data),
    .we_op    (do_add),
    .wa_op    (f_dst[AW-1:0]),
    .wd_op    (add_wrap(opa, opb)),
    .we_seed  (seed_we),
    .wa_seed  (seed_addr),
    .wd_seed  (seed_data),
    .any_write(rf_wrote)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= RESET_PC[PC_W-1:0];
      illegal    <= 1'b0;
      wide_valid <= 1'b0;
      wide_word  <= '0;
    end else begin
      illegal    <= accept && dec_bad;
      wide_valid <= accept && (fmt == FMT_WIDE);
      if (accept) pc <= pc + PC_W'(len_bytes);
      if (accept && (fmt == FMT_WIDE)) wide_word <= win_bytes;
    end
  end

  // R2: pc steps by the detected length, or holds
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pc - $past(pc)) == PC_W'($past(len_bytes)));
  // R3: idle edge keeps pc
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> $stable(pc));
  // R7/R8: the two pulses are exclusive
  a_r8_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, wide_valid}));
  // R7: illegal follows an accepted window
  a_r7_illegal_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal) |-> $past(accept) && ($past(len_bytes) == 4'd3));
  // R8: wide pulse follows an accepted wide window
  a_r8_wide_src: assert property (@(posedge clk) disable iff (!rst_n)
    wide_valid |-> $past(accept) && ($past(win_bytes[3:0]) == NIB_WIDE));
  // R4/R5/R9: file writes only for an add or a seed
  a_r9_write_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wrote |-> seed_we || (accept && !dec_bad && (fmt != FMT_WIDE)));
endmodule

// File: tb/mixlen_decode_core_tb_top.sv
module mixlen_decode_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_valid = 1'b0;
  logic [63:0] win_bytes = '0;
  logic        win_ready;
  logic [31:0] pc;
  logic        illegal, wide_valid;
  logic [63:0] wide_word;
  logic        seed_we = 1'b0;
  logic [3:0]  seed_addr = '0;
  logic [31:0] seed_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;

  always #2 clk = ~clk;

  mixlen_decode_core dut_i (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_bytes(win_bytes),
    .win_ready(win_ready), .pc(pc), .illegal(illegal), .wide_valid(wide_valid),
    .wide_word(wide_word), .seed_we(seed_we), .seed_addr(seed_addr),
    .seed_data(seed_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] m_reg [16];
  logic [31:0] m_pc;
  bit m_ill, m_wide;
  logic [63:0] m_word;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] base_add(int d, int a, int b);
    return {40'h0, 8'h80, 4'(d), 4'(a), 4'(b), 4'h0};
  endfunction
  function automatic logic [63:0] narrow_add(int d, int a, int b);
    return {48'h0, 4'(d), 4'(a), 4'(b), 4'hA};
  endfunction

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(bit v, logic [63:0] w);
    int n;
    win_valid = v; win_bytes = w;
    @(posedge clk);
    m_ill = 0; m_wide = 0;
    if (v) begin
      n = (w[3:0] == 4'hA) ? 2 : (w[3:0] == 4'hE) ? 8 : 3;
      if (n == 2 || (n == 3 && w[23:16] == 8'h80 && w[3:0] == 0))
        m_reg[w[15:12]] = m_reg[w[11:8]] + m_reg[w[7:4]];
      else if (n == 3) m_ill = 1;
      else begin m_wide = 1; m_word = w; end
      m_pc = m_pc + n;
    end
    @(negedge clk);
    win_valid = 0;
    chk("R2 pc", {32'h0, pc}, {32'h0, m_pc});
    chk("R7 illegal", {63'h0, illegal}, {63'h0, m_ill});
    chk("R8 wide_valid", {63'h0, wide_valid}, {63'h0, m_wide});
    if (m_wide) chk("R8 wide_word", wide_word, m_word);
  endtask

  task automatic seed(int a, logic [31:0] d);
    seed_we = 1; seed_addr = 4'(a); seed_data = d;
    @(posedge clk); m_reg[a] = d;
    @(negedge clk); seed_we = 0;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i); #0.5;
      chk(req, {32'h0, rd_data}, {32'h0, m_reg[i]});
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    m_pc = 0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", {32'h0, pc}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 illegal", {63'h0, illegal}, 64'h0);
    chk("R1 wide", {63'h0, wide_valid}, 64'h0);
    chk("R3 ready", {63'h0, win_ready}, 64'h1);
    sweep("R1 regs zero");
    for (int i = 1; i < 16; i++) seed(i, 32'h1000 * i + i);
    sweep("R9 seed");
    step(1, base_add(1, 2, 3));              // R4
    step(1, narrow_add(4, 5, 6));            // R5
    step(0, base_add(7, 1, 1));              // R3 idle
    step(1, 64'h0123_4567_89AB_CDEE);        // R8 wide
    step(1, 64'hFF_FF_FF_FF_FF_91_23_45);    // R7 bad base
    step(1, base_add(8, 8, 8));              // R6 d == sources
    step(1, narrow_add(9, 8, 1));            // R6 back-to-back
    sweep("R4 R5 R6 R7 R8 regs");
    seed(10, 32'hFFFF_FFF0);
    seed(11, 32'h0000_0020);
    step(1, narrow_add(12, 10, 11));         // R4 wrap
    // R9: seed and add on same destination, add wins
    seed_we = 1; seed_addr = 4'd13; seed_data = 32'hDEAD_BEEF;
    step(1, base_add(13, 1, 2));
    seed_we = 0;
    step(1, base_add(0, 0, 0));              // R7 nibble 0 but bad hi byte? no: add of zero reg
    step(1, {40'h0, 24'h7F_0000});           // R7 illegal
    for (int i = 0; i < 40; i++) begin       // R2 mixed order
      case (i % 4)
        0: step(1, narrow_add(i % 16, (i + 3) % 16, (i + 5) % 16));
        1: step(1, 64'hAAAA_5555_1234_567E);
        2: step(1, base_add((i + 1) % 16, i % 16, (i + 7) % 16));
        default: step(i % 8 == 3, {40'h0, 24'h21_0003});
      endcase
    end
    sweep("R2 R6 mixed regs");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule